// File: doc/BRIEF.md
# I2C Stop/Start Condition Sequencer

This block turns software requests for bus STOP and START conditions into an ordered series of commands for a bit-level I2C engine. Software writes two request flags: a start request and a stop request. A mode input selects master or slave behaviour. In master mode a stop request makes the block command a real STOP on the bus. In slave mode the same request is an error recovery. The block drives nothing on the wire. It raises a one-cycle internal event that returns the slave to its not-addressed receiver state, as if a STOP had been seen.

When both flags are set, the STOP (real or internal) always comes first, followed by a START. Every command to the engine is held until the engine answers with a one-cycle ready pulse, and only then does the next command go out. The block raises an interrupt pulse when a START completes and when a STOP appears on the bus that it did not cause itself. The echo of its own STOP, and its internal slave recovery, stay silent.

Top module: `i2c_cond_seq`

## Requirements
- R1: After a synchronous active-high reset, both request flags read 0, no command is driven, and the recovery event and the interrupt are low.
- R2: In master mode, a written stop request raises `cmd_stop` in the cycle after the write. The command stays high until `eng_ready` is seen, and the stop flag then reads 0.
- R3: In slave mode, a stop request never raises `cmd_stop`. It gives exactly one one-cycle `slave_recover` pulse, clears the stop flag, and raises no interrupt.
- R4: In master mode, with both flags set, a stop command is issued and acknowledged before the start command. The two commands are never high together.
- R5: In slave mode, with both flags set, the recovery pulse comes first, then a start command, and no stop command is issued.
- R6: A start request raises `cmd_start`, held until `eng_ready`. The start flag stays 1 afterwards. No further START is issued until software writes the start flag to 0 and then to 1 again.
- R7: The stop flag is set only by writing 1 to it. Writing 0 does not clear it, and with the flag at 0 no stop command or recovery occurs.
- R8: A `bus_stop_seen` strobe clears the stop flag. An already issued command is still held until it is acknowledged.
- R9: A `bus_stop_seen` strobe gives a one-cycle `irq` in the next cycle. It gives none while the block's own stop command is pending, and none for the first strobe after its own stop has been acknowledged.
- R10: Each acknowledged start command gives a one-cycle `irq` in the cycle after the acknowledge.
- R11: Reset in the middle of a pending command drops the command and both flags at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the request flags |
| wr_sta | input | 1 | Start request value; written as is |
| wr_sto | input | 1 | Stop request value; only 1 has an effect |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| bus_stop_seen | input | 1 | One-cycle strobe: STOP detected on the bus |
| eng_ready | input | 1 | One-cycle acknowledge from the bit engine |
| cmd_stop | output | 1 | Command: generate a STOP on the bus |
| cmd_start | output | 1 | Command: generate a START on the bus |
| slave_recover | output | 1 | One-cycle internal STOP event for slave recovery |
| irq | output | 1 | One-cycle interrupt request |
| sta_flag | output | 1 | Current start request flag |
| sto_flag | output | 1 | Current stop request flag |

## Verification
The assertions check on every cycle that the two commands are never high together and that each command stays high until it is acknowledged. They also check that the recovery pulse lasts one cycle and follows slave mode, that the stop flag rises only on a write, and that a bus STOP clears it. The ordering of STOP before START, the absence of a second START while the start flag stays set, and the silencing of the block's own STOP echo only show up in the bench's scenarios. That includes the full sweep over mode and flag combinations.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STOP  = 2'd1,
    SEQ_START = 2'd2
  } seq_state_e;

  // Choice made from idle: stop requests win over start requests.
  function automatic seq_state_e pick_from_idle(input logic master,
                                                input logic sto,
                                                input logic sta_pend);
    if (sto && master)      return SEQ_STOP;
    else if (sta_pend)      return SEQ_START;
    else                    return SEQ_IDLE;
  endfunction

  // Choice once a stop (real or internal) has finished.
  function automatic seq_state_e pick_after_stop(input logic sta_pend);
    return sta_pend ? SEQ_START : SEQ_IDLE;
  endfunction

endpackage

// File: rtl/i2c_req_flags.sv
module i2c_req_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sta,
  input  logic wr_sto,
  input  logic bus_stop_seen,
  input  logic sto_clr,
  input  logic start_ack,
  output logic sta_q,
  output logic sto_q,
  output logic sta_pend
);

  logic served_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q <= 1'b0;
    end else if (wr_en) begin
      sta_q <= wr_sta;
    end
  end

  // A served start stays blocked until software writes the flag to 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      served_q <= 1'b0;
    end else if (wr_en && !wr_sta) begin
      served_q <= 1'b0;
    end else if (start_ack) begin
      served_q <= 1'b1;
    end
  end

  // Software can only set the stop flag; hardware clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      sto_q <= 1'b0;
    end else if (wr_en && wr_sto) begin
      sto_q <= 1'b1;
    end else if (sto_clr || bus_stop_seen) begin
      sto_q <= 1'b0;
    end
  end

  assign sta_pend = sta_q && !served_q;

  a_r7_sto_set_by_write_only: assert property (@(posedge clk) disable iff (rst)
    $rose(sto_q) |-> $past(wr_en && wr_sto));

  a_r8_bus_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_stop_seen && !(wr_en && wr_sto)) |=> !sto_q);

  a_r6_sta_sticky: assert property (@(posedge clk) disable iff (rst)
    (sta_q && !wr_en) |=> sta_q);

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
  import i2c_cond_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic is_master,
  input  logic sto_q,
  input  logic sta_pend,
  input  logic eng_ready,
  output logic cmd_stop,
  output logic cmd_start,
  output logic slave_recover,
  output logic sto_clr,
  output logic stop_ack,
  output logic start_ack
);

  seq_state_e state_q, state_d;
  logic       recover_now;
  logic       recover_q;

  always_comb begin
    state_d     = state_q;
    recover_now = 1'b0;
    stop_ack    = 1'b0;
    start_ack   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (sto_q && !is_master) begin
          recover_now = 1'b1;
          state_d     = pick_after_stop(sta_pend);
        end else begin
          state_d = pick_from_idle(is_master, sto_q, sta_pend);
        end
      end
      SEQ_STOP: begin
        if (eng_ready) begin
          stop_ack = 1'b1;
          state_d  = pick_after_stop(sta_pend);
        end
      end
      SEQ_START: begin
        if (eng_ready) begin
          start_ack = 1'b1;
          state_d   = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_IDLE;
      recover_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      recover_q <= recover_now;
    end
  end

  assign sto_clr       = stop_ack || recover_now;
  assign cmd_stop      = (state_q == SEQ_STOP);
  assign cmd_start     = (state_q == SEQ_START);
  assign slave_recover = recover_q;

  a_r4_cmds_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_stop && cmd_start));

  a_r2_stop_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && !eng_ready) |=> cmd_stop);

  a_r6_start_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !eng_ready) |=> cmd_start);

  a_r3_recover_single: assert property (@(posedge clk) disable iff (rst)
    slave_recover |=> !slave_recover);

  a_r3_recover_in_slave: assert property (@(posedge clk) disable iff (rst)
    slave_recover |-> !$past(is_master));

endmodule

// File: rtl/i2c_irq_gen.sv
module i2c_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic bus_stop_seen,
  input  logic cmd_stop,
  input  logic stop_ack,
  input  logic start_ack,
  output logic irq
);

  logic own_stop_q;
  logic foreign_stop;

  // Remembers that the next bus STOP is the echo of a self-made one.
  always_ff @(posedge clk) begin
    if (rst) begin
      own_stop_q <= 1'b0;
    end else if (stop_ack) begin
      own_stop_q <= 1'b1;
    end else if (bus_stop_seen || start_ack) begin
      own_stop_q <= 1'b0;
    end
  end

  assign foreign_stop = bus_stop_seen && !own_stop_q && !cmd_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= start_ack || foreign_stop;
    end
  end

  a_r9_echo_silent: assert property (@(posedge clk) disable iff (rst)
    (own_stop_q && bus_stop_seen && !start_ack) |=> !irq);

  a_r10_start_irq: assert property (@(posedge clk) disable iff (rst)
    start_ack |=> irq);

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_sta,
  input  logic wr_sto,
  input  logic is_master,
  input  logic bus_stop_seen,
  input  logic eng_ready,
  output logic cmd_stop,
  output logic cmd_start,
  output logic slave_recover,
  output logic irq,
  output logic sta_flag,
  output logic sto_flag
);

  logic sta_q, sto_q, sta_pend;
  logic sto_clr, stop_ack, start_ack;

  i2c_req_flags u_flags (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sta       (wr_sta),
    .wr_sto       (wr_sto),
    .bus_stop_seen(bus_stop_seen),
    .sto_clr      (sto_clr),
    .start_ack    (start_ack),
    .sta_q        (sta_q),
    .sto_q        (sto_q),
    .sta_pend     (sta_pend)
  );

  i2c_cond_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .is_master    (is_master),
    .sto_q        (sto_q),
    .sta_pend     (sta_pend),
    .eng_ready    (eng_ready),
    .cmd_stop     (cmd_stop),
    .cmd_start    (cmd_start),
    .slave_recover(slave_recover),
    .sto_clr      (sto_clr),
    .stop_ack     (stop_ack),
    .start_ack    (start_ack)
  );

  i2c_irq_gen u_irq (
    .clk          (clk),
    .rst          (rst),
    .bus_stop_seen(bus_stop_seen),
    .cmd_stop     (cmd_stop),
    .stop_ack     (stop_ack),
    .start_ack    (start_ack),
    .irq          (irq)
  );

  assign sta_flag = sta_q;
  assign sto_flag = sto_q;

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_stop && !cmd_start && !slave_recover && !irq));

endmodule

// File: tb/sim_i2c_cond_seq.sv
module sim_i2c_cond_seq;

  logic clk = 1'b0;
  logic rst, wr_en, wr_sta, wr_sto, is_master, bus_stop_seen, eng_ready;
  logic cmd_stop, cmd_start, slave_recover, irq, sta_flag, sto_flag;
  int   checks = 0;
  int   failures = 0;

  always #4 clk = ~clk;

  i2c_cond_seq u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sta(wr_sta), .wr_sto(wr_sto),
    .is_master(is_master), .bus_stop_seen(bus_stop_seen), .eng_ready(eng_ready),
    .cmd_stop(cmd_stop), .cmd_start(cmd_start), .slave_recover(slave_recover),
    .irq(irq), .sta_flag(sta_flag), .sto_flag(sto_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; wr_sta = 0; wr_sto = 0;
    bus_stop_seen = 0; eng_ready = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic write_req(input logic a, input logic s);
    wr_en = 1'b1; wr_sta = a; wr_sto = s;
    tick();
    wr_en = 1'b0; wr_sta = 1'b0; wr_sto = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    is_master = 1'b1;
    do_reset();
    // R1: reset state
    check("R1 cmd_stop", cmd_stop, 0);
    check("R1 cmd_start", cmd_start, 0);
    check("R1 recover", slave_recover, 0);
    check("R1 irq", irq, 0);
    check("R1 sta_flag", sta_flag, 0);
    check("R1 sto_flag", sto_flag, 0);

    // Sweep over mode x start x stop (R2, R3, R4, R5, R10).
    // Events coded as digits: 1 = stop command, 2 = recovery, 3 = start command.
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 2; a++) begin
        for (int s = 0; s < 2; s++) begin
          int seq, exp_seq, irqs, both;
          logic prev_stop, prev_start;
          do_reset();
          is_master = m[0];
          write_req(a[0], s[0]);
          check("R6 sta written", sta_flag, a);
          check("R2 sto written", sto_flag, s);
          seq = 0; irqs = 0; both = 0; prev_stop = 0; prev_start = 0;
          for (int c = 0; c < 10; c++) begin
            tick();
            eng_ready = 1'b0;
            if (cmd_stop && cmd_start) both++;
            if (slave_recover) seq = seq * 10 + 2;
            if (cmd_stop && !prev_stop) seq = seq * 10 + 1;
            if (cmd_start && !prev_start) seq = seq * 10 + 3;
            if (irq) irqs++;
            prev_stop = cmd_stop; prev_start = cmd_start;
            eng_ready = cmd_stop || cmd_start;
          end
          eng_ready = 1'b0;
          exp_seq = 0;
          if (s != 0) exp_seq = (m != 0) ? 1 : 2;
          if (a != 0) exp_seq = exp_seq * 10 + 3;
          check(m ? "R4 master order" : "R5 slave order", seq, exp_seq);
          check("R4 never both", both, 0);
          check("R10 R3 irq count", irqs, a);
          check("R2 R3 sto cleared", sto_flag, 0);
          check("R6 sta kept", sta_flag, a);
        end
      end
    end

    // R6: start held until ready, no reissue until flag rewritten.
    do_reset(); is_master = 1'b1;
    write_req(1'b1, 1'b0);
    for (int c = 0; c < 4; c++) begin
      tick();
      check("R6 start held", cmd_start, 1);
    end
    eng_ready = 1'b1; tick(); eng_ready = 1'b0;
    check("R6 start dropped", cmd_start, 0);
    check("R10 irq after start", irq, 1);
    check("R6 sta sticky", sta_flag, 1);
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R6 no reissue", cmd_start, 0);
    end
    write_req(1'b0, 1'b0);
    write_req(1'b1, 1'b0);
    tick();
    check("R6 reissue after rewrite", cmd_start, 1);
    eng_ready = 1'b1; tick(); eng_ready = 1'b0;

    // R7: no stop without the flag; writing 0 does not clear it.
    do_reset(); is_master = 1'b1;
    write_req(1'b0, 1'b0);
    tick(); tick();
    check("R7 no stop cmd", cmd_stop, 0);
    check("R7 no start cmd", cmd_start, 0);
    check("R7 sto stays 0", sto_flag, 0);
    write_req(1'b0, 1'b1);
    tick();
    check("R2 stop cmd raised", cmd_stop, 1);
    write_req(1'b0, 1'b0);
    check("R7 zero write ignored", sto_flag, 1);
    check("R2 stop still held", cmd_stop, 1);

    // R8: bus stop clears flag, command still held; no irq (R9).
    bus_stop_seen = 1'b1; tick(); bus_stop_seen = 1'b0;
    check("R8 sto cleared by bus", sto_flag, 0);
    check("R8 cmd still held", cmd_stop, 1);
    check("R9 no irq own pending", irq, 0);

    // R11: reset mid-command.
    rst = 1'b1; tick(); rst = 1'b0;
    check("R11 cmd dropped", cmd_stop, 0);
    check("R11 sto cleared", sto_flag, 0);
    check("R11 sta cleared", sta_flag, 0);

    // R9: own stop echo silent, foreign stop raises irq.
    do_reset(); is_master = 1'b1;
    write_req(1'b0, 1'b1);
    tick();
    eng_ready = 1'b1; tick(); eng_ready = 1'b0;
    check("R2 stop acked", cmd_stop, 0);
    check("R9 no irq on ack", irq, 0);
    bus_stop_seen = 1'b1; tick(); bus_stop_seen = 1'b0;
    check("R9 echo silent", irq, 0);
    bus_stop_seen = 1'b1; tick(); bus_stop_seen = 1'b0;
    check("R9 foreign stop irq", irq, 1);
    tick();
    check("R9 irq one cycle", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule